// File: doc/BRIEF.md
# Host bus width and endian adapter

This block connects an external processor bus to a 32-bit internal register and memory fabric. Two static pins set the external bus mode. One pin selects a 16-bit or a 32-bit data path. The other selects little-endian or big-endian byte order. A third static pin picks the active controller role, host or device.

The block sorts each byte offset into one of five classes:
- shared registers;
- host-side registers;
- device-side registers;
- a 4 KB host RAM window;
- unmapped space.

Accesses to the region of the inactive role are refused. In 16-bit mode the host registers and the RAM window are reached only through pairs of half-word accesses. The block collects the two halves of a write and commits one 32-bit word. On a read it takes a 32-bit snapshot and hands it out one half at a time. The shared and device-side registers accept direct half-word accesses on data bits 15:0.

The internal side is a plain 32-bit slave port. It answers in the same cycle as the request. The register contents and the RAM itself live behind that port.

Top module: `hostbus_adapter`

## Requirements
- R1: Offsets are decoded as follows: 0x0000–0x00FF shared, 0x0100–0x02FF host registers, 0x0300–0x03FF device registers, 0x1000–0x1FFF RAM. Every other offset is unmapped. An access to an unmapped offset raises no internal request and is answered with `ext_err`=1. On a read it also returns 0xFFFFFFFF.
- R2: With `cfg_host_role`=1 the device register region is refused. With `cfg_host_role`=0 the host register and RAM regions are refused. A refused access raises no internal request, sets `ext_err`, and reads return 0xFFFFFFFF.
- R3: In 32-bit little-endian mode every permitted access is one internal transfer at the word-aligned offset, with the data passed through unchanged.
- R4: In 32-bit big-endian mode the two bytes inside each 16-bit half are exchanged in both directions: internal = {d[23:16], d[31:24], d[7:0], d[15:8]}.
- R5: In 16-bit mode, a write to the host register or RAM region at a word offset (offset bit 1 = 0) produces no internal write. The following write to offset+2 commits one 32-bit word. In little-endian order the first half forms bits 15:0 and the second half forms bits 31:16.
- R6: In 16-bit big-endian mode the half placement of R5 and R7 is reversed: the half at the offset is bits 31:16.
- R7: In 16-bit mode, a read of the host register or RAM region at the offset reads the full internal word once and returns its first half. The read at offset+2 returns the other half from that snapshot, even if the internal word changed in between. Both are zero-extended on `ext_rdata`.
- R8: In 16-bit mode, shared and device register accesses are single transfers at the given offset in either byte order. A write drives {16'h0, bus bits 15:0}. A read returns {16'h0, internal bits 15:0}.
- R9: A pending half is discarded when the next access is not its partner (same word, offset bit 1 = 1, same direction). This sets the sticky `proto_err`. A partner-less access at offset+2 gets `ext_err` and no internal transfer.
- R10: Each cycle with `ext_req` high is answered by `ext_ack` high for exactly the next cycle. `int_req` is only ever high in a cycle with `ext_req` high.
- R11: Reset clears `ext_ack`, `ext_err`, `proto_err` and any pending half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus16 | input | 1 | 1 = 16-bit external bus, 0 = 32-bit |
| cfg_big | input | 1 | 1 = big-endian, 0 = little-endian |
| cfg_host_role | input | 1 | 1 = host role active, 0 = device role active |
| ext_req | input | 1 | External access request, one cycle per access |
| ext_we | input | 1 | 1 = write, 0 = read |
| ext_addr | input | AW | Byte offset |
| ext_wdata | input | 32 | External write data (bits 15:0 in 16-bit mode) |
| ext_ack | output | 1 | Response strobe, the cycle after the request |
| ext_rdata | output | 32 | Read data, valid with `ext_ack` |
| ext_err | output | 1 | Access refused or unmapped, valid with `ext_ack` |
| proto_err | output | 1 | Sticky flag: a half-word pair was broken |
| int_req | output | 1 | Internal transfer request |
| int_we | output | 1 | Internal write enable |
| int_addr | output | AW | Internal byte offset |
| int_wdata | output | 32 | Internal write data |
| int_ack | input | 1 | Internal slave acknowledge, same cycle |
| int_rdata | input | 32 | Internal read data, same cycle |

## Verification
The bench reads every word offset under both roles and compares each result with a decode computed in the bench. A boundary slip by one word would return data where all-ones is expected, or the reverse. Each of the four bus modes gets half-word write pairs, read pairs and 32-bit round trips. Checks catch:
- a design that commits on the first half;
- one that swaps half placement for the wrong byte order;
- one that misses the byte exchange.

The bench changes the internal word between the two halves of a read. This exposes a design that re-reads instead of keeping its snapshot. Broken pairs and a reset taken between two halves show whether a stale half survives, leaking into a later word, and whether the sticky flag behaves.

// File: rtl/hba_pkg.sv
package hba_pkg;
  localparam int DW = 32;
  localparam int HW = DW / 2;

  localparam int SHARED_END = 'h100;
  localparam int HOSTREG_END = 'h300;
  localparam int DEVREG_END = 'h400;
  localparam int RAM_BASE = 'h1000;
  localparam int RAM_LAST = 'h1FFF;

  typedef enum logic [2:0] {
    REG_SHARED,
    REG_HOST,
    REG_DEV,
    REG_RAM,
    REG_NONE
  } region_e;

  function automatic logic [DW-1:0] swap_in_halves(input logic [DW-1:0] d);
    return {d[23:16], d[31:24], d[7:0], d[15:8]};
  endfunction
endpackage

// File: rtl/hba_decode.sv
module hba_decode
  import hba_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic [AW-1:0] addr,
  input  logic          host_role,
  output region_e       region,
  output logic          allowed,
  output logic          wide
);
  always_comb begin
    if (addr < AW'(SHARED_END)) begin
      region = REG_SHARED;
    end else if (addr < AW'(HOSTREG_END)) begin
      region = REG_HOST;
    end else if (addr < AW'(DEVREG_END)) begin
      region = REG_DEV;
    end else if (addr >= AW'(RAM_BASE) && addr <= AW'(RAM_LAST)) begin
      region = REG_RAM;
    end else begin
      region = REG_NONE;
    end
  end

  always_comb begin
    wide = (region == REG_HOST) || (region == REG_RAM);
    case (region)
      REG_SHARED: allowed = 1'b1;
      REG_HOST:   allowed = host_role;
      REG_RAM:    allowed = host_role;
      REG_DEV:    allowed = !host_role;
      default:    allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/hba_lanes.sv
module hba_lanes
  import hba_pkg::*;
(
  input  logic          big,
  input  logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] int_rdata,
  input  logic [DW-1:0] held,
  output logic [DW-1:0] wr_word,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] merged,
  output logic [HW-1:0] first_half,
  output logic [HW-1:0] second_half
);
  always_comb begin
    if (big) begin
      wr_word     = swap_in_halves(ext_wdata);
      rd_word     = swap_in_halves(int_rdata);
      merged      = {held[HW-1:0], ext_wdata[HW-1:0]};
      first_half  = int_rdata[DW-1:HW];
      second_half = held[HW-1:0];
    end else begin
      wr_word     = ext_wdata;
      rd_word     = int_rdata;
      merged      = {ext_wdata[HW-1:0], held[HW-1:0]};
      first_half  = int_rdata[HW-1:0];
      second_half = held[DW-1:HW];
    end
  end
endmodule

// File: rtl/hba_pair.sv
module hba_pair
  import hba_pkg::*;
#(
  parameter int AW = 13,
  localparam int WW = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          bus16,
  input  logic          wide_ok,
  input  logic          we,
  input  logic [WW-1:0] word,
  input  logic          upper,
  input  logic [HW-1:0] wdata_lo,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] held,
  output logic          is_first,
  output logic          is_second,
  output logic          is_orphan,
  output logic          proto_err
);
  logic          pend_q, pend_d;
  logic          pwe_q, pwe_d;
  logic [WW-1:0] pword_q, pword_d;
  logic [DW-1:0] held_q, held_d;
  logic          perr_q, perr_d;
  logic          paired, brk;

  always_comb begin
    paired    = fire && bus16 && wide_ok;
    is_first  = paired && !upper;
    is_second = pend_q && paired && upper && (we == pwe_q) && (word == pword_q);
    is_orphan = paired && upper && !is_second;
    brk       = pend_q && fire && !is_second;
  end

  always_comb begin
    pend_d  = pend_q;
    pwe_d   = pwe_q;
    pword_d = pword_q;
    held_d  = held_q;
    perr_d  = perr_q | brk | is_orphan;
    if (fire) begin
      pend_d = is_first;
    end
    if (is_first) begin
      pwe_d   = we;
      pword_d = word;
      held_d  = we ? {{HW{1'b0}}, wdata_lo} : rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pwe_q   <= 1'b0;
      pword_q <= '0;
      held_q  <= '0;
      perr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      perr_q <= perr_d;
      if (is_first) begin
        pwe_q   <= pwe_d;
        pword_q <= pword_d;
        held_q  <= held_d;
      end
    end
  end

  assign held      = held_q;
  assign proto_err = perr_q;
endmodule

// File: rtl/hostbus_adapter.sv
module hostbus_adapter
  import hba_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_bus16,
  input  logic          cfg_big,
  input  logic          cfg_host_role,
  input  logic          ext_req,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic          ext_ack,
  output logic [DW-1:0] ext_rdata,
  output logic          ext_err,
  output logic          proto_err,
  output logic          int_req,
  output logic          int_we,
  output logic [AW-1:0] int_addr,
  output logic [DW-1:0] int_wdata,
  input  logic          int_ack,
  input  logic [DW-1:0] int_rdata
);
  region_e       region;
  logic          allowed, wide;
  logic [DW-1:0] held, wr_word, rd_word, merged;
  logic [HW-1:0] first_half, second_half;
  logic          is_first, is_second, is_orphan;
  logic          ack_q, err_q, err_n;
  logic [DW-1:0] rdata_q, rdata_n;

  hba_decode #(.AW(AW)) u_decode (
    .addr     (ext_addr),
    .host_role(cfg_host_role),
    .region   (region),
    .allowed  (allowed),
    .wide     (wide)
  );

  hba_lanes u_lanes (
    .big        (cfg_big),
    .ext_wdata  (ext_wdata),
    .int_rdata  (int_rdata),
    .held       (held),
    .wr_word    (wr_word),
    .rd_word    (rd_word),
    .merged     (merged),
    .first_half (first_half),
    .second_half(second_half)
  );

  hba_pair #(.AW(AW)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (ext_req),
    .bus16    (cfg_bus16),
    .wide_ok  (allowed && wide),
    .we       (ext_we),
    .word     (ext_addr[AW-1:2]),
    .upper    (ext_addr[1]),
    .wdata_lo (ext_wdata[HW-1:0]),
    .rdata    (int_rdata),
    .held     (held),
    .is_first (is_first),
    .is_second(is_second),
    .is_orphan(is_orphan),
    .proto_err(proto_err)
  );

  // internal request steering
  always_comb begin
    int_req   = 1'b0;
    int_addr  = {ext_addr[AW-1:2], 2'b00};
    int_wdata = wr_word;
    if (ext_req && allowed) begin
      if (!cfg_bus16) begin
        int_req = 1'b1;
      end else if (!wide) begin
        int_req   = 1'b1;
        int_addr  = {ext_addr[AW-1:1], 1'b0};
        int_wdata = {{HW{1'b0}}, ext_wdata[HW-1:0]};
      end else if (is_first && !ext_we) begin
        int_req = 1'b1;
      end else if (is_second && ext_we) begin
        int_req   = 1'b1;
        int_wdata = merged;
      end
    end
    int_we = int_req && ext_we;
  end

  // response next state
  always_comb begin
    err_n = !allowed || is_orphan || (int_req && !int_ack);
    if (err_n) begin
      rdata_n = '1;
    end else if (ext_we) begin
      rdata_n = '0;
    end else if (!cfg_bus16) begin
      rdata_n = rd_word;
    end else if (!wide) begin
      rdata_n = {{HW{1'b0}}, int_rdata[HW-1:0]};
    end else if (is_first) begin
      rdata_n = {{HW{1'b0}}, first_half};
    end else begin
      rdata_n = {{HW{1'b0}}, second_half};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= ext_req;
      if (ext_req) begin
        err_q   <= err_n;
        rdata_q <= rdata_n;
      end
    end
  end

  assign ext_ack   = ack_q;
  assign ext_err   = err_q;
  assign ext_rdata = rdata_q;
endmodule

// File: rtl/hba_checker.sv
module hba_checker #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_bus16,
  input logic          cfg_host_role,
  input logic          ext_req,
  input logic          ext_we,
  input logic [AW-1:0] ext_addr,
  input logic          ext_ack,
  input logic          ext_err,
  input logic [31:0]   ext_rdata,
  input logic          proto_err,
  input logic          int_req,
  input logic          int_we,
  input logic [AW-1:0] int_addr
);
  logic int_dev, int_hostside, int_mapped, ext_hostside;

  always_comb begin
    int_dev      = int_addr >= AW'('h300) && int_addr < AW'('h400);
    int_hostside = (int_addr >= AW'('h100) && int_addr < AW'('h300)) || int_addr >= AW'('h1000);
    int_mapped   = int_addr < AW'('h400) || int_addr >= AW'('h1000);
    ext_hostside = (ext_addr >= AW'('h100) && ext_addr < AW'('h300)) || ext_addr >= AW'('h1000);
  end

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) ext_req |=> ext_ack); // R10
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n) !ext_req |=> !ext_ack); // R10
  AST_INT_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n) int_req |-> ext_req); // R10
  AST_UNMAPPED_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n) int_req |-> int_mapped); // R1
  AST_ERR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_we ##1 ext_ack && ext_err |-> ext_rdata == 32'hFFFF_FFFF); // R1
  AST_HOST_ROLE_BLOCKS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && cfg_host_role |-> !int_dev); // R2
  AST_DEV_ROLE_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !cfg_host_role |-> !int_hostside); // R2
  AST_PAIR_COMMIT_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && int_we && cfg_bus16 && ext_hostside |-> ext_addr[1]); // R5
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> proto_err); // R9
endmodule

bind hostbus_adapter hba_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_bus16    (cfg_bus16),
  .cfg_host_role(cfg_host_role),
  .ext_req      (ext_req),
  .ext_we       (ext_we),
  .ext_addr     (ext_addr),
  .ext_ack      (ext_ack),
  .ext_err      (ext_err),
  .ext_rdata    (ext_rdata),
  .proto_err    (proto_err),
  .int_req      (int_req),
  .int_we       (int_we),
  .int_addr     (int_addr)
);

// File: tb/tb_hostbus_adapter.sv
`timescale 1ns/1ps
module tb_hostbus_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bus16 = 1'b0, cfg_big = 1'b0, cfg_host_role = 1'b1;
  logic        ext_req = 1'b0, ext_we = 1'b0;
  logic [12:0] ext_addr = '0;
  logic [31:0] ext_wdata = '0;
  logic        ext_ack, ext_err, proto_err;
  logic [31:0] ext_rdata;
  logic        int_req, int_we, int_ack;
  logic [12:0] int_addr;
  logic [31:0] int_wdata, int_rdata;

  logic [31:0] mem [0:2047];
  int          wr_cnt = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  hostbus_adapter #(.AW(13)) dut (.*);

  assign int_ack   = int_req;
  assign int_rdata = mem[int_addr[12:2]];
  always @(posedge clk) begin
    if (int_req && int_we) begin
      mem[int_addr[12:2]] <= int_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [31:0] pat(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ i;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[23:16], d[31:24], d[7:0], d[15:8]};
  endfunction

  function automatic bit exp_err(input logic [12:0] a, input bit host);
    if (a < 13'h100) return 1'b0;
    if (a < 13'h300) return !host;
    if (a < 13'h400) return host;
    if (a >= 13'h1000) return !host;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [12:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    ext_req = 1'b1; ext_we = we; ext_addr = a; ext_wdata = d;
    @(negedge clk);
    ext_req = 1'b0;
    chk(ext_ack == 1'b1, "R10 ack", {31'b0, ext_ack}, 32'h1);
    rd = ext_rdata;
    er = ext_err;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, d, pre;
    logic        er;
    int          wc;
    for (int i = 0; i < 2048; i++) mem[i] = pat(i);
    do_reset();
    // R11 reset state
    chk(ext_ack == 1'b0, "R11 ack", {31'b0, ext_ack}, 32'h0);
    chk(proto_err == 1'b0, "R11 proto", {31'b0, proto_err}, 32'h0);

    // R1 R2 R3 full word sweep, 32-bit little, both roles
    for (int role = 0; role < 2; role++) begin
      cfg_host_role = role[0];
      for (int w = 0; w < 2048; w++) begin
        acc(1'b0, 13'(w * 4), 32'h0, rd, er);
        chk(er == exp_err(13'(w * 4), role[0]), "R1/R2 decode err", {31'b0, er}, {31'b0, exp_err(13'(w * 4), role[0])});
        if (exp_err(13'(w * 4), role[0])) chk(rd == 32'hFFFF_FFFF, "R1 ones", rd, 32'hFFFF_FFFF);
        else chk(rd == mem[w], "R3 read", rd, mem[w]);
      end
    end

    cfg_host_role = 1'b1;
    for (int m = 0; m < 4; m++) begin
      cfg_bus16 = m[1];
      cfg_big   = m[0];
      if (!cfg_bus16) begin
        d = 32'hA1B2_C3D4 ^ m;
        acc(1'b1, 13'h120, d, rd, er);
        chk(mem[13'h120 >> 2] == (cfg_big ? bswap(d) : d), "R3/R4 write lanes", mem[13'h120 >> 2], cfg_big ? bswap(d) : d);
        acc(1'b0, 13'h120, 32'h0, rd, er);
        chk(rd == d, "R3/R4 round trip", rd, d);
        acc(1'b1, 13'h1FFC, ~d, rd, er);
        chk(mem[2047] == (cfg_big ? bswap(~d) : ~d), "R4 ram top", mem[2047], cfg_big ? bswap(~d) : ~d);
      end else begin
        // R5 R6 write pair, host region then RAM
        for (int r = 0; r < 2; r++) begin
          logic [12:0] base;
          logic [31:0] expw;
          base = (r == 0) ? 13'h124 : 13'h1008;
          wc = wr_cnt;
          acc(1'b1, base, 32'hFFFF_0000 | (16'h5A10 + m), rd, er);
          chk(wr_cnt == wc && !er, "R5 no commit on first half", 32'(wr_cnt - wc), 32'h0);
          acc(1'b1, base + 13'd2, 32'hFFFF_C3D4, rd, er);
          expw = cfg_big ? {16'h5A10 + 16'(m), 16'hC3D4} : {16'hC3D4, 16'h5A10 + 16'(m)};
          chk(mem[base >> 2] == expw, cfg_big ? "R6 big pair write" : "R5 pair write", mem[base >> 2], expw);
          chk(wr_cnt == wc + 1, "R5 single commit", 32'(wr_cnt - wc), 32'h1);
        end
        // R7 R6 read pair snapshot
        mem[13'h128 >> 2] = 32'h1122_3344;
        acc(1'b0, 13'h128, 32'h0, rd, er);
        chk(rd == {16'h0, cfg_big ? 16'h1122 : 16'h3344}, "R7 first half", rd, {16'h0, cfg_big ? 16'h1122 : 16'h3344});
        mem[13'h128 >> 2] = 32'h5566_7788;
        acc(1'b0, 13'h12A, 32'h0, rd, er);
        chk(rd == {16'h0, cfg_big ? 16'h3344 : 16'h1122}, "R7 snapshot second half", rd, {16'h0, cfg_big ? 16'h3344 : 16'h1122});
        // R8 shared region direct half
        acc(1'b1, 13'h012, 32'hFFFF_5A6B ^ m, rd, er);
        chk(mem[4] == (32'h0000_5A6B ^ m), "R8 shared write", mem[4], 32'h0000_5A6B ^ m);
        acc(1'b0, 13'h012, 32'h0, rd, er);
        chk(rd == (32'h0000_5A6B ^ m), "R8 shared read", rd, 32'h0000_5A6B ^ m);
      end
    end

    // R2 blocking of writes
    cfg_bus16 = 1'b0; cfg_big = 1'b0;
    cfg_host_role = 1'b0;
    pre = mem[13'h130 >> 2]; wc = wr_cnt;
    acc(1'b1, 13'h130, 32'hDEAD_BEEF, rd, er);
    chk(er && mem[13'h130 >> 2] == pre && wr_cnt == wc, "R2 device role refuses host write", mem[13'h130 >> 2], pre);
    acc(1'b1, 13'h300, 32'h0BAD_F00D, rd, er);
    chk(!er && mem[13'h300 >> 2] == 32'h0BAD_F00D, "R2 device role writes device reg", mem[13'h300 >> 2], 32'h0BAD_F00D);
    cfg_host_role = 1'b1;
    acc(1'b1, 13'h300, 32'h1234_5678, rd, er);
    chk(er && mem[13'h300 >> 2] == 32'h0BAD_F00D, "R2 host role refuses device write", mem[13'h300 >> 2], 32'h0BAD_F00D);

    // R9 broken pair
    cfg_bus16 = 1'b1;
    chk(proto_err == 1'b0, "R9 clean before", {31'b0, proto_err}, 32'h0);
    pre = mem[13'h140 >> 2];
    acc(1'b1, 13'h140, 32'h0000_1111, rd, er);
    acc(1'b0, 13'h144, 32'h0, rd, er);
    chk(proto_err == 1'b1, "R9 sticky set", {31'b0, proto_err}, 32'h1);
    acc(1'b1, 13'h142, 32'h0000_2222, rd, er);
    chk(er == 1'b1, "R9 orphan err", {31'b0, er}, 32'h1);
    chk(mem[13'h140 >> 2] == pre, "R9 discarded half", mem[13'h140 >> 2], pre);
    @(negedge clk);
    chk(ext_ack == 1'b0 && proto_err == 1'b1, "R10 ack drops, R9 stays", {30'b0, ext_ack, proto_err}, 32'h1);

    // R11 reset clears pending half
    pre = mem[13'h150 >> 2];
    acc(1'b1, 13'h150, 32'h0000_3333, rd, er);
    do_reset();
    chk(proto_err == 1'b0, "R11 proto cleared", {31'b0, proto_err}, 32'h0);
    acc(1'b1, 13'h152, 32'h0000_4444, rd, er);
    chk(er == 1'b1 && mem[13'h150 >> 2] == pre, "R11 pending dropped", mem[13'h150 >> 2], pre);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule